// File: doc/BRIEF.md
# Base-Delta-Immediate Line Codec

This block shrinks a 64-byte cache line into one of five fixed encodings and expands such an encoding back into the original line. It sees the line as eight 64-bit words, the first of which serves as the base. Each encoding has a fixed payload size: 0, 8, 16, 24 or 64 bytes. The compressor picks the smallest encoding that represents the line exactly. It returns a 3-bit form code, a 512-bit packed payload and the payload size in bytes. It also raises a one-cycle event whenever a line was actually compressed.

The two directions work independently of each other, and each has a latency of one clock. A storage controller presents a line on the compress side and keeps the form code with the payload. Later it hands both to the expand side to recover the line. Where compressed lines are placed, and which line is evicted, is left to the caller.

Top module: `bdi_line_codec`

## Requirements
- R1: After reset, `cmp_valid_o`, `cmp_hit_o` and `dec_valid_o` are 0.
- R2: A line whose 64 bytes are all zero gets form code 0 and a size of 0. Its payload is all zero.
- R3: A nonzero line whose eight words are all equal gets form code 1 and a size of 8. The payload holds that word in bits [63:0] and zero above.
- R4: A line gets form code 2 and a size of 16 when it fails R2 and R3 and every word minus word 0 lies in [-128, 127]. The payload holds word 0 in bits [63:0] and the low byte of the difference for word i in bits [64+8i +: 8], with zero above bit 127.
- R5: A line gets form code 3 and a size of 24 when it fails R2 to R4 and every difference lies in [-32768, 32767]. The payload holds word 0 in bits [63:0] and the low 16 bits of difference i in bits [64+16i +: 16], with zero above bit 191.
- R6: Any other line gets form code 4 and a size of 64, and the payload equals the line.
- R7: When several forms could encode a line, the one with the lower code is chosen.
- R8: Differences are taken modulo 2^64, so words that wrap around the 64-bit range still count as small deltas.
- R9: `cmp_hit_o` pulses for exactly the cycle in which `cmp_valid_o` is high with a form code other than 4.
- R10: `cmp_valid_o` is high in the cycle after `cmp_valid_i` is high and low otherwise. The same holds for `dec_valid_o` after `dec_valid_i`.
- R11: The expander, given a form code from 0 to 4 and a payload produced by the compressor, returns the original line one cycle later. It rebuilds each word as base plus the sign-extended delta, modulo 2^64.
- R12: The expander returns an all-zero line for form codes 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid_i | input | 1 | Line to compress is present |
| cmp_line_i | input | 512 | Line to compress; word i in bits [64i +: 64] |
| cmp_valid_o | output | 1 | Compression result is present |
| cmp_form_o | output | 3 | Chosen form code (0 zero, 1 repeat, 2 delta8, 3 delta16, 4 raw) |
| cmp_payload_o | output | 512 | Packed payload, little end first |
| cmp_bytes_o | output | 7 | Payload size in bytes |
| cmp_hit_o | output | 1 | One-cycle pulse when the line was compressed |
| dec_valid_i | input | 1 | Encoded line to expand is present |
| dec_form_i | input | 3 | Form code of the encoded line |
| dec_payload_i | input | 512 | Packed payload of the encoded line |
| dec_valid_o | output | 1 | Expanded line is present |
| dec_line_o | output | 512 | Expanded line |

## Verification
The bench places single words exactly at the delta limits of +127, -128, +128, -32768 and +32768. A fit test that is off by one bit would put one of these lines into the wrong form, and a round trip with a truncated delta would return a corrupted word. Other lines can be encoded several ways, such as a repeated word or a zero base followed by small nonzero words. A design with its priority swapped would return a larger form than needed. A line that wraps past 2^64 checks that the arithmetic is modular. Without that, the line would be stored raw, or the base would be added back with the wrong sign. Unused form codes are fed to the expander to show that stale data does not leak out. A hit pulse that stays high, or that fires on raw lines, shows up in the cycle after each result.

// File: rtl/bdi_line_codec.sv
module bdi_line_codec #(
  parameter int WORD_BITS = 64,
  parameter int WORDS     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmp_valid_i,
  input  logic [WORD_BITS*WORDS-1:0]   cmp_line_i,
  output logic                         cmp_valid_o,
  output logic [2:0]                   cmp_form_o,
  output logic [WORD_BITS*WORDS-1:0]   cmp_payload_o,
  output logic [6:0]                   cmp_bytes_o,
  output logic                         cmp_hit_o,
  input  logic                         dec_valid_i,
  input  logic [2:0]                   dec_form_i,
  input  logic [WORD_BITS*WORDS-1:0]   dec_payload_i,
  output logic                         dec_valid_o,
  output logic [WORD_BITS*WORDS-1:0]   dec_line_o
);
  localparam int LB = WORD_BITS * WORDS;
  localparam logic [2:0] F_ZERO = 3'd0, F_REP = 3'd1, F_D8 = 3'd2,
                         F_D16 = 3'd3, F_RAW = 3'd4;

  logic [WORD_BITS-1:0] word [WORDS];
  logic [WORD_BITS-1:0] diff [WORDS];
  logic [WORDS-1:0] nz, same, fit8, fit16;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign word[g]  = cmp_line_i[g*WORD_BITS +: WORD_BITS];
    assign diff[g]  = word[g] - word[0];
    assign nz[g]    = |word[g];
    assign same[g]  = ~|diff[g];
    assign fit8[g]  = (&diff[g][WORD_BITS-1:7])  | ~|diff[g][WORD_BITS-1:7];
    assign fit16[g] = (&diff[g][WORD_BITS-1:15]) | ~|diff[g][WORD_BITS-1:15];
  end

  logic [2:0]    form_c;
  logic [LB-1:0] pay_c;
  logic [6:0]    bytes_c;

  always_comb begin
    if (~|nz)          form_c = F_ZERO;
    else if (&same)    form_c = F_REP;
    else if (&fit8)    form_c = F_D8;
    else if (&fit16)   form_c = F_D16;
    else               form_c = F_RAW;
  end

  always_comb begin
    pay_c = '0;
    unique case (form_c)
      F_ZERO: pay_c = '0;
      F_REP:  pay_c[WORD_BITS-1:0] = word[0];
      F_D8: begin
        pay_c[WORD_BITS-1:0] = word[0];
        for (int i = 0; i < WORDS; i++) pay_c[WORD_BITS+8*i +: 8] = diff[i][7:0];
      end
      F_D16: begin
        pay_c[WORD_BITS-1:0] = word[0];
        for (int i = 0; i < WORDS; i++) pay_c[WORD_BITS+16*i +: 16] = diff[i][15:0];
      end
      default: pay_c = cmp_line_i;
    endcase
  end

  always_comb begin
    unique case (form_c)
      F_ZERO:  bytes_c = 7'd0;
      F_REP:   bytes_c = 7'(WORD_BITS/8);
      F_D8:    bytes_c = 7'(WORD_BITS/8 + WORDS);
      F_D16:   bytes_c = 7'(WORD_BITS/8 + 2*WORDS);
      default: bytes_c = 7'(LB/8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_valid_o   <= 1'b0;
      cmp_hit_o     <= 1'b0;
      cmp_form_o    <= F_ZERO;
      cmp_payload_o <= '0;
      cmp_bytes_o   <= '0;
    end else begin
      cmp_valid_o <= cmp_valid_i;
      cmp_hit_o   <= cmp_valid_i && (form_c != F_RAW);
      if (cmp_valid_i) begin
        cmp_form_o    <= form_c;
        cmp_payload_o <= pay_c;
        cmp_bytes_o   <= bytes_c;
      end
    end
  end

  logic [WORD_BITS-1:0] base_d;
  logic [LB-1:0]        line_c;
  assign base_d = dec_payload_i[WORD_BITS-1:0];

  always_comb begin
    line_c = '0;
    unique case (dec_form_i)
      F_ZERO: line_c = '0;
      F_REP:
        for (int i = 0; i < WORDS; i++) line_c[i*WORD_BITS +: WORD_BITS] = base_d;
      F_D8:
        for (int i = 0; i < WORDS; i++)
          line_c[i*WORD_BITS +: WORD_BITS] =
            base_d + {{(WORD_BITS-8){dec_payload_i[WORD_BITS+8*i+7]}},
                      dec_payload_i[WORD_BITS+8*i +: 8]};
      F_D16:
        for (int i = 0; i < WORDS; i++)
          line_c[i*WORD_BITS +: WORD_BITS] =
            base_d + {{(WORD_BITS-16){dec_payload_i[WORD_BITS+16*i+15]}},
                      dec_payload_i[WORD_BITS+16*i +: 16]};
      F_RAW:  line_c = dec_payload_i;
      default: line_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_line_o  <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) dec_line_o <= line_c;
    end
  end
endmodule

// File: rtl/bdi_line_codec_chk.sv
module bdi_line_codec_chk #(
  parameter int WORD_BITS = 64,
  parameter int WORDS     = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmp_valid_i,
  input logic [WORD_BITS*WORDS-1:0] cmp_line_i,
  input logic                       cmp_valid_o,
  input logic [2:0]                 cmp_form_o,
  input logic [WORD_BITS*WORDS-1:0] cmp_payload_o,
  input logic [6:0]                 cmp_bytes_o,
  input logic                       cmp_hit_o,
  input logic                       dec_valid_i,
  input logic [2:0]                 dec_form_i,
  input logic [WORD_BITS*WORDS-1:0] dec_payload_i,
  input logic                       dec_valid_o,
  input logic [WORD_BITS*WORDS-1:0] dec_line_o
);
  p_cmp_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid_i |=> cmp_valid_o);
  p_cmp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid_i |=> !cmp_valid_o);
  p_dec_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_valid_o);
  p_hit_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit_o == (cmp_valid_o && cmp_form_o != 3'd4));
  p_zero_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && cmp_line_i == '0) |=> (cmp_form_o == 3'd0 && cmp_payload_o == '0));
  p_raw_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_o && cmp_form_o == 3'd4) |-> cmp_payload_o == $past(cmp_line_i));
  p_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid_o |-> (cmp_form_o <= 3'd4 &&
      cmp_bytes_o == (cmp_form_o == 3'd0 ? 7'd0 : cmp_form_o == 3'd1 ? 7'd8 :
                      cmp_form_o == 3'd2 ? 7'd16 : cmp_form_o == 3'd3 ? 7'd24 : 7'd64)));
  p_bad_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_form_i > 3'd4) |=> dec_line_o == '0);
endmodule

bind bdi_line_codec bdi_line_codec_chk #(.WORD_BITS(WORD_BITS), .WORDS(WORDS)) u_chk (.*);

// File: tb/bdi_line_codec_tb.sv
module bdi_line_codec_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_valid_i = 1'b0, dec_valid_i = 1'b0;
  logic [511:0] cmp_line_i = '0, dec_payload_i = '0;
  logic [2:0] dec_form_i = '0;
  logic cmp_valid_o, cmp_hit_o, dec_valid_o;
  logic [2:0] cmp_form_o;
  logic [511:0] cmp_payload_o, dec_line_o;
  logic [6:0] cmp_bytes_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bdi_line_codec u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] ramp(input logic [63:0] base, input logic [63:0] step);
    logic [511:0] l;
    for (int i = 0; i < 8; i++) l[64*i +: 64] = base + 64'(i) * step;
    return l;
  endfunction

  function automatic logic [511:0] put(input logic [511:0] l, input int idx, input logic [63:0] v);
    l[64*idx +: 64] = v;
    return l;
  endfunction

  function automatic logic [511:0] exp_pay(input logic [2:0] f, input logic [511:0] l);
    logic [511:0] p = '0;
    logic [63:0] d;
    case (f)
      3'd1: p[63:0] = l[63:0];
      3'd2: begin
        p[63:0] = l[63:0];
        for (int i = 0; i < 8; i++) begin d = l[64*i +: 64] - l[63:0]; p[64+8*i +: 8] = d[7:0]; end
      end
      3'd3: begin
        p[63:0] = l[63:0];
        for (int i = 0; i < 8; i++) begin d = l[64*i +: 64] - l[63:0]; p[64+16*i +: 16] = d[15:0]; end
      end
      3'd4: p = l;
      default: p = '0;
    endcase
    return p;
  endfunction

  task automatic compress_case(input string req, input logic [511:0] line, input logic [2:0] ef);
    logic [6:0] eb;
    logic [511:0] pay;
    logic [2:0] fm;
    eb = (ef == 0) ? 7'd0 : (ef == 1) ? 7'd8 : (ef == 2) ? 7'd16 : (ef == 3) ? 7'd24 : 7'd64;
    @(negedge clk); cmp_valid_i = 1'b1; cmp_line_i = line;
    @(negedge clk); cmp_valid_i = 1'b0;
    chk(cmp_valid_o === 1'b1, {req, " valid"}, 512'(cmp_valid_o), 512'(1));
    chk(cmp_form_o === ef, {req, " form"}, 512'(cmp_form_o), 512'(ef));
    chk(cmp_bytes_o === eb, {req, " bytes"}, 512'(cmp_bytes_o), 512'(eb));
    chk(cmp_payload_o === exp_pay(ef, line), {req, " payload"}, cmp_payload_o, exp_pay(ef, line));
    chk(cmp_hit_o === (ef != 3'd4), {req, " R9 hit"}, 512'(cmp_hit_o), 512'(ef != 3'd4));
    pay = cmp_payload_o; fm = cmp_form_o;
    dec_valid_i = 1'b1; dec_form_i = fm; dec_payload_i = pay;
    @(negedge clk); dec_valid_i = 1'b0;
    chk(cmp_valid_o === 1'b0 && cmp_hit_o === 1'b0, {req, " R9 R10 pulse ends"},
        512'({cmp_valid_o, cmp_hit_o}), 512'(0));
    chk(dec_valid_o === 1'b1 && dec_line_o === line, {req, " R11 round trip"}, dec_line_o, line);
  endtask

  task automatic bad_code_case(input logic [2:0] code);
    @(negedge clk); dec_valid_i = 1'b1; dec_form_i = code; dec_payload_i = ramp(64'hDEAD_BEEF, 64'h1111);
    @(negedge clk); dec_valid_i = 1'b0;
    chk(dec_valid_o === 1'b1 && dec_line_o === '0, "R12 unused code", dec_line_o, '0);
  endtask

  task automatic reset_case();
    chk(cmp_valid_o === 1'b0 && cmp_hit_o === 1'b0 && dec_valid_o === 1'b0, "R1 reset",
        512'({cmp_valid_o, cmp_hit_o, dec_valid_o}), 512'(0));
  endtask

  task automatic idle_case();
    @(negedge clk); @(negedge clk);
    chk(cmp_valid_o === 1'b0 && dec_valid_o === 1'b0, "R10 idle",
        512'({cmp_valid_o, dec_valid_o}), 512'(0));
  endtask

  initial begin
    logic [63:0] b;
    repeat (3) @(negedge clk);
    reset_case();
    rst_n = 1'b1;
    idle_case();
    compress_case("R2 zero", '0, 3'd0);
    compress_case("R3 R7 repeat", ramp(64'h1234_5678_9ABC_DEF0, 64'd0), 3'd1);
    compress_case("R4 ramp", ramp(64'd1000, 64'd3), 3'd2);
    b = 64'h0000_0400_0000_0000;
    compress_case("R4 plus127", put(ramp(b, 0) , 7, b + 64'd127), 3'd2);
    compress_case("R4 minus128", put(ramp(b, 0), 3, b - 64'd128), 3'd2);
    compress_case("R5 plus128", put(ramp(b, 0), 5, b + 64'd128), 3'd3);
    compress_case("R5 minus32768", put(ramp(b, 0), 2, b - 64'd32768), 3'd3);
    compress_case("R5 ramp", ramp(b, 64'd4000), 3'd3);
    compress_case("R6 plus32768", put(ramp(b, 0), 6, b + 64'd32768), 3'd4);
    compress_case("R6 noisy", ramp(64'h0123_4567_89AB_CDEF, 64'h1357_9BDF_0246_8ACE), 3'd4);
    compress_case("R8 wrap", ramp(64'hFFFF_FFFF_FFFF_FFFD, 64'd1), 3'd2);
    compress_case("R7 zero base", put(put('0, 1, 64'd5), 4, 64'hFFFF_FFFF_FFFF_FFF0), 3'd2);
    bad_code_case(3'd5);
    bad_code_case(3'd6);
    bad_code_case(3'd7);
    idle_case();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule